// File: doc/BRIEF.md
# Page-Mode Asynchronous Read Controller

This block is the host side of a 16-bit pseudo-static RAM running in asynchronous page mode. A client hands it a word address and a word count on a valid/ready port. The controller then holds chip enable, output enable, the address-valid strobe and both byte enables low, and it steps the address one word at a time. Each word is captured from the data bus when its wait count expires and is returned with a one-cycle valid strobe. The final word of a request also carries a last flag.

Memory words are grouped into 16-word pages, selected by the low four address bits. The first word of a request, and any word whose upper address bits differ from those of the word before it, waits the full random-access time. A word that stays in the same page waits only the short page time. The memory's refresh limits how long chip enable may stay low, so the controller counts the low cycles. When the next word would push the count past the limit, the controller raises chip enable for a single cycle and restarts with a full access. All three times are parameters counted in controller clock cycles.

The memory clock pin is tied low and write enable is tied high. The memory's wait pin is not connected, because its level carries no meaning in this mode.

Top module: `pgrd_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, mem_ce_n, mem_oe_n, mem_adv_n, mem_lb_n, mem_ub_n and mem_we_n are 1, mem_clk is 0, req_ready is 1 and rd_valid is 0.
- R2: A request accepted with address A and length L returns L+1 words in order from addresses A, A+1, …, wrapping modulo 2^ADDR_W. Each rd_data equals the mem_dq value present at that word's address, and rd_last is 1 only on the final word.
- R3: The first word of a request appears on rd_valid T_INIT+1 cycles after the accepting clock edge. The controller spends T_INIT cycles with CE low on it, then one output register stage.
- R4: A word whose address bits [ADDR_W-1:4] equal those of the previous word appears T_PAGE cycles after the previous word, provided R6 does not intervene.
- R5: A word whose address bits [ADDR_W-1:4] differ from those of the previous word, including a wrap from all-ones to zero, appears T_INIT cycles after the previous word, provided R6 does not intervene.
- R6: mem_ce_n is never low for more than T_CEMAX consecutive cycles. When the low cycles used so far plus the next word's wait would exceed T_CEMAX, mem_ce_n goes high for exactly one cycle and the next word takes a full access, so it appears T_INIT+1 cycles after the previous word.
- R7: While mem_ce_n is low, mem_addr stays unchanged for at least the wait count of the word being read, ending with the cycle in which that word is captured.
- R8: In the cycle that presents the last word, mem_ce_n is 1 and req_ready is 1. req_ready is never 1 while mem_ce_n is 0.
- R9: mem_clk is always 0 and mem_we_n is always 1. mem_oe_n, mem_adv_n, mem_lb_n and mem_ub_n each equal mem_ce_n in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Starting word address |
| req_len | input | LEN_W | Number of words minus one |
| mem_addr | output | ADDR_W | Memory word address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_clk | output | 1 | Memory clock, held low |
| mem_dq | input | DATA_W | Memory read data |
| rd_valid | output | 1 | Returned word valid, one cycle |
| rd_data | output | DATA_W | Returned word |
| rd_last | output | 1 | Returned word is the last of its request |

## Verification
The page tracker and the chip-enable window can both act on the same word. This happens when a step leaves a page at the moment the low-time budget is also exhausted. In that case the word must take one high cycle and then a single full access, never two stacked penalties. A directed request starting at offset 9 with the default timings lines the budget overrun up exactly with the crossing to the next page, and a second request breaks inside a page so that the two causes are also seen apart. The bench models the per-word gaps from the timing parameters and checks each word's arrival cycle, data and last flag against that model. Random requests at random page offsets mix both events further.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_GAP  = 2'd2
  } pgrd_state_e;

endpackage

// File: rtl/pgrd_lat.sv
// Per-word wait counter: picks page or full access time and counts it down.
module pgrd_lat #(
  parameter int T_INIT = 6,
  parameter int T_PAGE = 2,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic             load_full,
  input  logic             same_page,
  output logic             done,
  output logic [CNT_W-1:0] next_len
);

  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(T_INIT);
  localparam logic [CNT_W-1:0] LEN_PAGE = CNT_W'(T_PAGE);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] wcnt_q;
  logic [CNT_W-1:0] wcnt_d;
  logic             wcnt_en;

  assign next_len = same_page ? LEN_PAGE : LEN_FULL;
  assign done     = run && (wcnt_q == '0);

  always_comb begin
    wcnt_d  = wcnt_q;
    wcnt_en = 1'b0;
    if (load) begin
      wcnt_en = 1'b1;
      wcnt_d  = (load_full ? LEN_FULL : next_len) - ONE;
    end else if (run && (wcnt_q != '0)) begin
      wcnt_en = 1'b1;
      wcnt_d  = wcnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wcnt_q <= '0;
    else if (wcnt_en) wcnt_q <= wcnt_d;
  end

  AST_NEW_PAGE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !same_page) |=> (wcnt_q == LEN_FULL - ONE)); // R5

  AST_WAIT_HELD_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(wcnt_q)); // R6

endmodule

// File: rtl/pgrd_cewin.sv
// Chip-enable low-time window: tells whether the next word still fits.
module pgrd_cewin #(
  parameter int T_CEMAX = 20,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_low,
  input  logic [CNT_W-1:0] need,
  output logic             fits
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   LIMIT   = (CNT_W+1)'(T_CEMAX);

  logic [CNT_W-1:0] low_q;
  logic [CNT_W-1:0] low_d;
  logic [CNT_W:0]   used_after;

  // cycles already low (low_q), plus the current one, plus the next word
  assign used_after = {1'b0, low_q} + {1'b0, need} + (CNT_W+1)'(1);
  assign fits       = (used_after <= LIMIT);

  always_comb begin
    if (!ce_low)               low_d = '0;
    else if (low_q != CNT_TOP) low_d = low_q + CNT_W'(1);
    else                       low_d = low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_d;
  end

  AST_CE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ce_low |-> ({1'b0, low_q} < LIMIT)); // R6

endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
  import pgrd_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = 8,
  parameter int PAGE_W  = 4,
  parameter int T_INIT  = 6,
  parameter int T_PAGE  = 2,
  parameter int T_CEMAX = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic              mem_clk,
  input  logic [DATA_W-1:0] mem_dq,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);

  localparam int CNT_W = $clog2(T_CEMAX + T_INIT + 2) + 1;

  pgrd_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_inc;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              ld, ld_full, cap, same_page, done, fits, reading;
  logic [CNT_W-1:0]  next_len;
  logic              rdv_q, last_q;
  logic [DATA_W-1:0] data_q;

  assign reading   = (state_q == ST_READ);
  assign addr_inc  = addr_q + ADDR_W'(1);
  assign same_page = (addr_q[ADDR_W-1:PAGE_W] == addr_inc[ADDR_W-1:PAGE_W]);

  pgrd_lat #(.T_INIT(T_INIT), .T_PAGE(T_PAGE), .CNT_W(CNT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .run(reading), .load(ld), .load_full(ld_full),
    .same_page(same_page), .done(done), .next_len(next_len)
  );

  pgrd_cewin #(.T_CEMAX(T_CEMAX), .CNT_W(CNT_W)) u_cewin (
    .clk(clk), .rst_n(rst_n), .ce_low(reading), .need(next_len), .fits(fits)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    ld      = 1'b0;
    ld_full = 1'b0;
    cap     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_READ;
          addr_d  = req_addr;
          rem_d   = req_len;
          ld      = 1'b1;
          ld_full = 1'b1;
        end
      end
      ST_READ: begin
        if (done) begin
          cap = 1'b1;
          if (rem_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            addr_d = addr_inc;
            rem_d  = rem_q - LEN_W'(1);
            ld     = 1'b1;
            if (!fits) begin
              state_d = ST_GAP;
              ld_full = 1'b1;
            end
          end
        end
      end
      ST_GAP:  state_d = ST_READ;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      rdv_q  <= cap;
      last_q <= cap && (rem_q == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (cap) data_q <= mem_dq;
  end

  assign req_ready = (state_q == ST_IDLE);
  assign mem_addr  = addr_q;
  assign mem_ce_n  = !reading;
  assign mem_oe_n  = !reading;
  assign mem_adv_n = !reading;
  assign mem_lb_n  = !reading;
  assign mem_ub_n  = !reading;
  assign mem_we_n  = 1'b1;
  assign mem_clk   = 1'b0;
  assign rd_valid  = rdv_q;
  assign rd_data   = data_q;
  assign rd_last   = last_q;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !done) |=> $stable(mem_addr)); // R7

  AST_LAST_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_last) |-> (mem_ce_n && req_ready)); // R8

  AST_GAP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n) && !req_ready) |=> !mem_ce_n); // R6

  AST_VALID_AFTER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!mem_ce_n)); // R2

endmodule

// File: tb/sim_pgrd_ctrl.sv
`timescale 1ns/1ps
module sim_pgrd_ctrl;

  localparam int AW = 22;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int TI = 6;
  localparam int TP = 2;
  localparam int TC = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_adv_n, mem_lb_n, mem_ub_n, mem_clk;
  logic [DW-1:0] mem_dq;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          rd_last;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    return a[15:0] ^ {a[21:16], a[9:0]} ^ 16'h5A3C;
  endfunction

  assign mem_dq = mem_oe_n ? '0 : word_of(mem_addr);

  pgrd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .PAGE_W(4),
              .T_INIT(TI), .T_PAGE(TP), .T_CEMAX(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_adv_n(mem_adv_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_clk(mem_clk), .mem_dq(mem_dq), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // cycle monitor, sampled just after each rising edge
  int            stab, stab_prev, ce_run;
  logic [AW-1:0] addr_last, addr_prev;
  logic          ce_last;
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      stab = 0; stab_prev = 0; ce_run = 0; ce_last = 1'b1; addr_last = '0; addr_prev = '0;
    end else begin
      stab_prev = stab;
      addr_prev = addr_last;
      if (!mem_ce_n && !ce_last && mem_addr == addr_last) stab = stab + 1;
      else if (!mem_ce_n) stab = 1;
      else stab = 0;
      addr_last = mem_addr;
      ce_last   = mem_ce_n;
      ce_run    = mem_ce_n ? 0 : ce_run + 1;
      chk(ce_run <= TC, "R6 ce low run", ce_run, TC);
      chk(mem_clk == 1'b0 && mem_we_n == 1'b1 && mem_oe_n == mem_ce_n &&
          mem_adv_n == mem_ce_n && mem_lb_n == mem_ce_n && mem_ub_n == mem_ce_n,
          "R9 pin levels", {mem_clk, mem_we_n, mem_oe_n, mem_adv_n, mem_lb_n, mem_ub_n},
          {1'b0, 1'b1, {4{mem_ce_n}}});
      chk(!(req_ready && !mem_ce_n), "R8 ready with ce low", req_ready, 0);
    end
  end

  // issue one request and check every returned word against the timing model
  task automatic run_req(input logic [AW-1:0] a0, input logic [LW-1:0] len);
    logic [AW-1:0] a;
    int n, w, celow, k;
    bit early;
    string tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a0; req_len = len;
    @(posedge clk);
    a = a0; n = TI + 1; w = TI; celow = TI; tag = "R3 first word";
    for (k = 0; k <= int'(len); k++) begin
      early = 0;
      for (int i = 1; i <= n; i++) begin
        @(negedge clk);
        req_valid = 1'b0;
        if (i < n && rd_valid) early = 1;
      end
      chk(rd_valid && !early, tag, {early, rd_valid}, 1);
      chk(rd_data == word_of(a), "R2 data", rd_data, word_of(a));
      chk(rd_last == (k == int'(len)), "R2 last", rd_last, (k == int'(len)));
      chk(stab_prev >= w && addr_prev == a, "R7 address hold", stab_prev, w);
      if (k == int'(len)) begin
        chk(mem_ce_n && req_ready, "R8 ce high at end", {mem_ce_n, req_ready}, 2'b11);
      end else begin
        logic [AW-1:0] nx;
        nx = a + 1'b1;
        w  = (nx[AW-1:4] == a[AW-1:4]) ? TP : TI;
        if (celow + w > TC) begin
          n = TI + 1; w = TI; celow = TI; tag = "R6 break gap";
        end else begin
          n = w; celow = celow + w;
          tag = (w == TP) ? "R4 page word" : "R5 new page word";
        end
        a = nx;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_adv_n && mem_lb_n && mem_ub_n && mem_we_n &&
        !mem_clk && req_ready && !rd_valid, "R1 in reset",
        {mem_ce_n, mem_oe_n, mem_adv_n, mem_lb_n, mem_ub_n, mem_we_n, mem_clk, req_ready, rd_valid},
        9'b111111010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && req_ready && !rd_valid, "R1 after release",
        {mem_ce_n, req_ready, rd_valid}, 3'b110);
    // directed corners
    run_req(22'h000000, 8'd0);    // R3 single word
    run_req(22'h000000, 8'd9);    // R6 break inside a page
    run_req(22'h000009, 8'd12);   // R6 and R5 on the same word
    run_req(22'h00000E, 8'd3);    // R5 crossing without break
    run_req(22'h3FFFFF, 8'd1);    // R5 wrap to zero
    run_req(22'h000100, 8'd40);   // R6 repeated breaks
    for (int r = 0; r < 40; r++) begin
      run_req(AW'($urandom), LW'($urandom_range(0, 31)));
    end
    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule